// File: doc/BRIEF.md
# NAND Page Read Pointer Sequencer

This block is the read side of a small-page NAND flash device, seen from inside the device. A host writes command and address bytes over a shared 8-bit bus, with one select line for commands and one for addresses. The block keeps a column pointer into a 528-byte page. Each page has 512 main bytes at columns 0..511 and 16 spare bytes at columns 512..527.

Three read commands choose where the pointer may start:
- 00h selects the lower main half.
- 01h selects the upper main half.
- 50h selects the spare bytes.

The spare selection is sticky. It stays in force until a 00h command ends it.

After one column byte and two row bytes, the device goes busy while it loads the page. It then hands out one byte per read strobe. When the pointer passes the last column, the device loads the next page on its own and restarts at the base column of the current region. Reading stops when the next page would lie in another block. The page contents come from a computed store, so that the bench can predict every byte.

Top module: `nandPageReader`

## Requirements
- R1: After reset the device is ready (`devReady`=1), `ioOe`=0 and `ioOut`=0, and the region is the lower main half.
- R2: A 00h command followed by column byte C sets the start column to C (0..255). Successive strobes then return columns C, C+1, ... up to 527.
- R3: A 01h command given while in a main-area region sets the start column to 256+C.
- R4: A 50h command sets the start column to 512 + C[3:0]. Bits C[7:4] have no effect, and while streaming in the spare region the column never drops below 512.
- R5: The spare region is sticky. After 50h, a 01h read still starts at 512 + C[3:0]. Only 00h returns the pointer to the main area.
- R6: The byte at row R and column K is (K mod 256) XOR 64*(K div 256) XOR (R mod 256), as 8 bits. The column advances by one on each completed strobe.
- R7: The address phase has three bytes in this order: column byte, row low byte, row high byte. The row is {high,low} modulo 32*BLOCKS, and page index = row mod 32. `devReady` goes low on the clock after the third address byte and stays low for exactly BUSY_CYCLES cycles.
- R8: While busy, read strobes are ignored. `ioOe` stays 0, and the first byte after busy is still the start column.
- R9: `ioOe`=1 only when the device is streaming, `chipSelN`=0 and `rdEnN`=0. Otherwise `ioOut`=0, and a strobe taken with `chipSelN`=1 does not move the pointer.
- R10: A strobe completed at column 527 on a page whose index is below 31 makes the device busy for BUSY_CYCLES cycles. The row then advances by one and the column restarts at 0, 256 or 512 for the current region.
- R11: A strobe completed at column 527 on page index 31 stops reading. The device stays ready, with no busy period, and strobes drive nothing until a new read command and new address bytes are given.
- R12: Commands other than 00h, 01h and 50h, and address bytes given outside the address phase, change neither the pointer nor the region. A read command given on the same clock as a strobe completing at column 527 takes priority, and no page crossing happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipSelN | input | 1 | Active-low device select |
| cmdSel | input | 1 | Bus byte is a command when written |
| addrSel | input | 1 | Bus byte is an address when written |
| wrPulse | input | 1 | One-cycle write strobe that latches `ioIn` |
| rdEnN | input | 1 | Active-low read strobe; releasing it advances the pointer |
| ioIn | input | 8 | Command or address byte from the host |
| ioOut | output | 8 | Data byte at the current column, 0 when not driven |
| ioOe | output | 1 | Output drive enable |
| devReady | output | 1 | High when ready, low while a page is loading |

## Verification
Two events can fall on the same clock edge: the release of a read strobe at column 527, which would start a page crossing, and a new read command that restarts the sequence. The bench places the pointer on column 527 through a spare-region read. It then lowers the strobe, and on one negative edge raises the strobe and writes a 00h command together. The result is judged at the ports. `devReady` must stay high, because the crossing was dropped. The following address phase must then start a fresh read at the new row and column, in the lower main region.

// File: rtl/nandSeqPkg.sv
package nandSeqPkg;

  localparam int COL_W      = 10;
  localparam int LAST_COL   = 527;
  localparam int SPARE_BASE = 512;
  localparam int UPPER_BASE = 256;

  typedef enum logic [1:0] {
    REGION_LOWER = 2'd0,
    REGION_UPPER = 2'd1,
    REGION_SPARE = 2'd2
  } region_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ADDR  = 2'd1,
    SEQ_BUSY  = 2'd2,
    SEQ_READY = 2'd3
  } seqState_t;

  // Strobes from control to the pointer datapath
  typedef struct packed {
    logic    ldCol;
    logic    ldRowLo;
    logic    ldRowHi;
    logic    incCol;
    logic    nextPage;
    region_t region;
  } seqStrobe_t;

  function automatic logic [COL_W-1:0] regionBase(input region_t r);
    case (r)
      REGION_UPPER: regionBase = COL_W'(UPPER_BASE);
      REGION_SPARE: regionBase = COL_W'(SPARE_BASE);
      default:      regionBase = '0;
    endcase
  endfunction

endpackage

// File: rtl/nandPatternArray.sv
module nandPatternArray #(
  parameter int ROW_W = 7
) (
  input  logic [ROW_W-1:0]               rowAddr,
  input  logic [nandSeqPkg::COL_W-1:0]   colAddr,
  output logic [7:0]                     cellByte
);
  logic [15:0] rowExt;
  logic [7:0]  regionMask;

  assign rowExt     = 16'(rowAddr);
  // column bits 9:8 tag the quarter of the page in the top two data bits (R6)
  assign regionMask = {colAddr[9:8], 6'b0};
  assign cellByte   = colAddr[7:0] ^ regionMask ^ rowExt[7:0];
endmodule

// File: rtl/nandSeqDatapath.sv
module nandSeqDatapath
  import nandSeqPkg::*;
#(
  parameter int PAGES_PER_BLOCK = 32,
  parameter int BLOCKS          = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strb,
  input  logic [7:0]           busByte,
  output logic [COL_W-1:0]     colAddr,
  output logic [$clog2(PAGES_PER_BLOCK*BLOCKS)-1:0] rowAddr,
  output logic                 lastCol,
  output logic                 lastPage
);
  localparam int PAGE_W = $clog2(PAGES_PER_BLOCK);
  localparam int ROW_W  = $clog2(PAGES_PER_BLOCK*BLOCKS);

  logic [7:0]  rowLo;
  logic [15:0] rowFull;

  assign rowFull  = {busByte, rowLo};
  assign lastCol  = (colAddr == COL_W'(LAST_COL));
  assign lastPage = (rowAddr[PAGE_W-1:0] == PAGE_W'(PAGES_PER_BLOCK-1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colAddr <= '0;
      rowAddr <= '0;
      rowLo   <= '0;
    end else begin
      if (strb.ldCol) begin
        case (strb.region)
          REGION_UPPER: colAddr <= {2'b01, busByte};
          REGION_SPARE: colAddr <= COL_W'(SPARE_BASE) + COL_W'(busByte[3:0]);
          default:      colAddr <= {2'b00, busByte};
        endcase
      end else if (strb.incCol) begin
        colAddr <= colAddr + 1'b1;
      end else if (strb.nextPage) begin
        colAddr <= regionBase(strb.region);
      end
      if (strb.ldRowLo) rowLo <= busByte;
      if (strb.ldRowHi) rowAddr <= rowFull[ROW_W-1:0];
      else if (strb.nextPage) rowAddr <= rowAddr + 1'b1;
    end
  end

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.incCol |=> colAddr == $past(colAddr) + 1'b1); // R6
  AST_COL_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    colAddr <= COL_W'(LAST_COL)); // R2
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.nextPage |=> rowAddr == $past(rowAddr) + 1'b1); // R10
endmodule

// File: rtl/nandSeqCtrl.sv
module nandSeqCtrl
  import nandSeqPkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSelN,
  input  logic       cmdSel,
  input  logic       addrSel,
  input  logic       wrPulse,
  input  logic       rdEnN,
  input  logic [7:0] busByte,
  input  logic       lastCol,
  input  logic       lastPage,
  output seqStrobe_t strb,
  output logic       devReady,
  output logic       streaming
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  seqState_t   state;
  region_t     region;
  logic [1:0]  addrIdx;
  logic [BUSY_W-1:0] busyCnt;
  logic        armed;
  logic        cmdEv, readCmd, addrEv, advance;

  assign cmdEv   = wrPulse && !chipSelN && cmdSel && !addrSel;
  assign readCmd = cmdEv && (busByte == 8'h00 || busByte == 8'h01 || busByte == 8'h50);
  assign addrEv  = wrPulse && !chipSelN && addrSel && !cmdSel && (state == SEQ_ADDR);
  // a read command on the same edge wins over the strobe (R12)
  assign advance = armed && rdEnN && (state == SEQ_READY) && !readCmd;

  assign devReady  = (state != SEQ_BUSY);
  assign streaming = (state == SEQ_READY);

  always_comb begin
    strb        = '0;
    strb.region = region;
    if (addrEv) begin
      strb.ldCol   = (addrIdx == 2'd0);
      strb.ldRowLo = (addrIdx == 2'd1);
      strb.ldRowHi = (addrIdx == 2'd2);
    end
    if (advance) begin
      strb.incCol   = !lastCol;
      strb.nextPage = lastCol && !lastPage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SEQ_IDLE;
      region  <= REGION_LOWER;
      addrIdx <= '0;
      busyCnt <= '0;
      armed   <= 1'b0;
    end else begin
      armed <= streaming && !chipSelN && !rdEnN;
      if (readCmd) begin
        case (busByte)
          8'h00:   region <= REGION_LOWER;
          8'h50:   region <= REGION_SPARE;
          default: if (region != REGION_SPARE) region <= REGION_UPPER; // R5
        endcase
        state   <= SEQ_ADDR;
        addrIdx <= '0;
      end else begin
        case (state)
          SEQ_ADDR: if (addrEv) begin
            if (addrIdx == 2'd2) begin
              state   <= SEQ_BUSY;
              busyCnt <= BUSY_W'(BUSY_CYCLES - 1);
            end else begin
              addrIdx <= addrIdx + 1'b1;
            end
          end
          SEQ_BUSY: begin
            if (busyCnt == '0) state <= SEQ_READY;
            else busyCnt <= busyCnt - 1'b1;
          end
          SEQ_READY: if (advance && lastCol) begin
            if (lastPage) state <= SEQ_IDLE;
            else begin
              state   <= SEQ_BUSY;
              busyCnt <= BUSY_W'(BUSY_CYCLES - 1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_BUSY) |-> busyCnt < BUSY_W'(BUSY_CYCLES)); // R7
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (advance && lastCol && !lastPage) |=> !devReady); // R10
  AST_BLOCK_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (advance && lastCol && lastPage) |=> devReady && !streaming); // R11
  AST_SPARE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (region == REGION_SPARE && !(readCmd && busByte == 8'h00)) |=> region == REGION_SPARE); // R5
endmodule

// File: rtl/nandPageReader.sv
module nandPageReader
  import nandSeqPkg::*;
#(
  parameter int PAGES_PER_BLOCK = 32,
  parameter int BLOCKS          = 4,
  parameter int BUSY_CYCLES     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSelN,
  input  logic       cmdSel,
  input  logic       addrSel,
  input  logic       wrPulse,
  input  logic       rdEnN,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut,
  output logic       ioOe,
  output logic       devReady
);
  localparam int ROW_W = $clog2(PAGES_PER_BLOCK*BLOCKS);

  seqStrobe_t       strb;
  logic             streaming, lastCol, lastPage;
  logic [COL_W-1:0] colAddr;
  logic [ROW_W-1:0] rowAddr;
  logic [7:0]       cellByte;

  nandSeqCtrl #(.BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .cmdSel(cmdSel),
    .addrSel(addrSel), .wrPulse(wrPulse), .rdEnN(rdEnN), .busByte(ioIn),
    .lastCol(lastCol), .lastPage(lastPage), .strb(strb),
    .devReady(devReady), .streaming(streaming)
  );

  nandSeqDatapath #(.PAGES_PER_BLOCK(PAGES_PER_BLOCK), .BLOCKS(BLOCKS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busByte(ioIn),
    .colAddr(colAddr), .rowAddr(rowAddr), .lastCol(lastCol), .lastPage(lastPage)
  );

  nandPatternArray #(.ROW_W(ROW_W)) arr_i (
    .rowAddr(rowAddr), .colAddr(colAddr), .cellByte(cellByte)
  );

  assign ioOe  = streaming && !chipSelN && !rdEnN;
  assign ioOut = ioOe ? cellByte : 8'h00;

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !devReady |-> !ioOe); // R8
  AST_SPARE_REGION: assert property (@(posedge clk) disable iff (!rstN)
    (streaming && strb.region == REGION_SPARE) |-> colAddr >= COL_W'(SPARE_BASE)); // R4
endmodule

// File: tb/nandPageReader_tb_top.sv
`timescale 1ns/1ps
module nandPageReader_tb_top;
  localparam int BUSY = 8;

  logic clk = 0, rstN = 0;
  logic chipSelN = 0, cmdSel = 0, addrSel = 0, wrPulse = 0, rdEnN = 1;
  logic [7:0] ioIn = 0;
  logic [7:0] ioOut;
  logic ioOe, devReady;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nandPageReader #(.PAGES_PER_BLOCK(32), .BLOCKS(4), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .cmdSel(cmdSel), .addrSel(addrSel),
    .wrPulse(wrPulse), .rdEnN(rdEnN), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe),
    .devReady(devReady)
  );

  function automatic logic [7:0] expByte(int row, int col);
    int quarter = col / 256;
    return 8'((col % 256) ^ (quarter * 64) ^ (row % 256));
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic putCmd(logic [7:0] b);
    @(negedge clk); cmdSel = 1; ioIn = b; wrPulse = 1;
    @(negedge clk); cmdSel = 0; wrPulse = 0;
  endtask

  task automatic putAddr(logic [7:0] b);
    @(negedge clk); addrSel = 1; ioIn = b; wrPulse = 1;
    @(negedge clk); addrSel = 0; wrPulse = 0;
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (!devReady && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic startRead(logic [7:0] cmd, logic [7:0] colB, int row, output int busyLen);
    putCmd(cmd);
    putAddr(colB);
    putAddr(8'(row));
    putAddr(8'(row >> 8));
    waitReady(busyLen);
  endtask

  task automatic strobe(output logic [7:0] b, output logic oe);
    @(negedge clk); rdEnN = 0; #1; b = ioOut; oe = ioOe;
    @(negedge clk); rdEnN = 1;
    @(negedge clk);
  endtask

  task automatic readSpan(int row, int fromCol, int toCol, string tag);
    logic [7:0] b; logic oe; int bad = 0, badAct = 0, badExp = 0;
    for (int c = fromCol; c <= toCol; c++) begin
      strobe(b, oe);
      if (!oe || b !== expByte(row, c)) begin
        if (bad == 0) begin badAct = b; badExp = expByte(row, c); end
        bad++;
      end
    end
    check(bad == 0, tag, badAct, badExp);
  endtask

  task automatic testReset();
    check(devReady === 1'b1, "R1 ready after reset", devReady, 1);
    check(ioOe === 1'b0 && ioOut === 8'h00, "R1 no drive after reset", ioOut, 0);
  endtask

  task automatic testLowerAndWrap();
    int n;
    startRead(8'h00, 8'd5, 3, n);
    check(n == BUSY, "R7 busy length", n, BUSY);
    readSpan(3, 5, 527, "R2 R6 lower span 5..527");
    waitReady(n);
    check(n == BUSY, "R10 page crossing busy", n, BUSY);
    readSpan(4, 0, 3, "R10 next page restarts at 0");
  endtask

  task automatic testUpper();
    int n;
    startRead(8'h01, 8'h10, 7, n);
    readSpan(7, 272, 274, "R3 upper half start 272");
  endtask

  task automatic testSpare();
    int n;
    startRead(8'h50, 8'hA3, 2, n);
    readSpan(2, 515, 527, "R4 spare start ignores high bits");
    waitReady(n);
    check(n == BUSY, "R10 spare crossing busy", n, BUSY);
    readSpan(3, 512, 513, "R10 spare restart at 512");
  endtask

  task automatic testSticky();
    int n;
    startRead(8'h01, 8'h00, 9, n);
    readSpan(9, 512, 513, "R5 upper cmd stays in spare");
    startRead(8'h00, 8'h00, 9, n);
    readSpan(9, 0, 1, "R5 lower cmd leaves spare");
  endtask

  task automatic testBusyIgnore();
    int n; bit sawOe = 0;
    putCmd(8'h00); putAddr(8'h40); putAddr(8'd6); putAddr(8'd0);
    @(negedge clk); rdEnN = 0; #1; sawOe = ioOe;
    @(negedge clk); rdEnN = 1;
    check(!sawOe, "R8 no drive while busy", sawOe, 0);
    waitReady(n);
    readSpan(6, 64, 64, "R8 strobe in busy did not advance");
  endtask

  task automatic testGating();
    int n; bit oeA, oeB; logic [7:0] outA;
    startRead(8'h00, 8'd20, 8, n);
    @(negedge clk); chipSelN = 1; rdEnN = 0; #1; oeA = ioOe; outA = ioOut;
    @(negedge clk); rdEnN = 1;
    @(negedge clk); chipSelN = 0; #1; oeB = ioOe;
    check(!oeA && outA == 8'h00, "R9 deselected no drive", int'(outA), 0);
    check(!oeB, "R9 strobe high no drive", oeB, 0);
    readSpan(8, 20, 20, "R9 deselected strobe did not advance");
  endtask

  task automatic testIgnored();
    int n;
    startRead(8'h00, 8'd10, 5, n);
    readSpan(5, 10, 10, "R12 first byte");
    putCmd(8'h90);
    putAddr(8'h77);
    readSpan(5, 11, 11, "R12 stray cmd and addr ignored");
  endtask

  task automatic testBlockStop();
    int n; logic [7:0] b; logic oe;
    startRead(8'h50, 8'h08, 30, n);
    readSpan(30, 520, 527, "R11 page 30 tail");
    waitReady(n);
    readSpan(31, 512, 527, "R11 page 31 spare");
    @(negedge clk);
    check(devReady === 1'b1, "R11 no busy at block end", devReady, 1);
    strobe(b, oe);
    check(!oe, "R11 stopped drives nothing", oe, 0);
    startRead(8'h00, 8'd0, 32, n);
    readSpan(32, 0, 0, "R11 fresh read after stop");
  endtask

  task automatic testCollision();
    int n; logic rdyAfter;
    startRead(8'h50, 8'h0F, 1, n);
    @(negedge clk); rdEnN = 0; #1;
    check(ioOe && ioOut == expByte(1, 527), "R12 at column 527", ioOut, expByte(1, 527));
    @(negedge clk); rdEnN = 1; cmdSel = 1; ioIn = 8'h00; wrPulse = 1;
    @(negedge clk); cmdSel = 0; wrPulse = 0; rdyAfter = devReady;
    check(rdyAfter === 1'b1, "R12 command beats page crossing", rdyAfter, 1);
    putAddr(8'h20); putAddr(8'd12); putAddr(8'd0);
    waitReady(n);
    readSpan(12, 32, 33, "R12 new read after collision");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testLowerAndWrap();
    testUpper();
    testSpare();
    testSticky();
    testBusyIgnore();
    testGating();
    testIgnored();
    testBlockStop();
    testCollision();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule